// File: doc/BRIEF.md
# DMA Stream Event Flag Bank

This block holds the event flags of an eight-stream DMA unit. Each stream engine reports five kinds of event as single-cycle pulses: FIFO error, direct-mode error, transfer error, half transfer and transfer complete. Each pulse sets a sticky flag. The flags of streams 0 to 3 are packed into one 32-bit status word, and those of streams 4 to 7 into a second status word that uses the same layout. Software reads the flags through a small register port. It clears a flag by writing a one to the matching bit of a separate clear word, so no read-modify-write is needed.

Each stream also drives its own interrupt line. The line is high while at least one of the stream's flags is set and that flag's enable bit is on. The stream engines and the enable register live outside this block.

Top module: `dma_status_bank`

## Requirements
- R1: After reset every flag is clear, every `irq_o` bit is low and every register address reads zero.
- R2: A one on `evt_i[s*5+f]` at a rising clock edge sets flag f of stream s, and the flag is visible from that edge on. The kind codes are f=0 FIFO error, 1 direct-mode error, 2 transfer error, 3 half transfer and 4 transfer complete. The flag stays set until it is cleared.
- R3: Address 0 reads streams 0-3 and address 1 reads streams 4-7. Within each word the group of stream lane l (stream mod 4) starts at bit 0, 6, 16 and 22 for l = 0, 1, 2 and 3. Inside a group, FIFO error sits at relative bit 0, direct-mode error at 2, transfer error at 3, half transfer at 4 and transfer complete at 5.
- R4: Bits that carry no flag always read zero. These are relative bit 1 of every group and word bits 12-15 and 28-31.
- R5: A write to address 2 (streams 0-3) or address 3 (streams 4-7) clears, at that edge, every flag whose bit position in the R3 layout holds a one. Zero bits in the written word leave their flags unchanged.
- R6: Writes to address 0 or address 1 change no flag.
- R7: If an event pulse and a clear write hit the same flag at the same edge, the flag ends up set.
- R8: `irq_o[s]` is high exactly when some flag f of stream s is set and `irq_en_i[s*5+f]` is high. The index f uses the codes of R2. The output follows flag and enable changes with no added register.
- R9: Addresses 2 and 3 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 40 | Event pulses, bit s*5+f (kind codes of R2) |
| irq_en_i | input | 40 | Interrupt enables, same indexing as evt_i |
| reg_addr_i | input | 2 | Register word address: 0/1 status, 2/3 clear |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 8 | Per-stream interrupt request |

## Verification
A flag set by an event or removed by a clear write changes at the rising edge that samples the pulse or the write. It therefore shows on `reg_rdata_o` and `irq_o` from that edge on, one cycle after the stimulus is driven. Read data and interrupt lines are combinational, so they follow a change of address or enable within the same cycle. The bench drives every input at the falling edge. At the next falling edge it compares outputs against a model that it has updated with the effect of the edge in between. Every result is therefore checked in the first cycle it is due, with no race against the active edge.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int unsigned FLAG_KINDS   = 5;
  localparam int unsigned LANES_PER_WD = 4;
  localparam int unsigned WORD_BITS    = 32;

  // Start bit of a stream lane's group inside a status or clear word.
  function automatic int unsigned lane_base(input int unsigned lane);
    case (lane)
      0:       return 0;
      1:       return 6;
      2:       return 16;
      3:       return 22;
      default: return 0;
    endcase
  endfunction

  // Position of a flag kind inside its group; relative bit 1 is left empty.
  function automatic int unsigned kind_pos(input int unsigned kind);
    return (kind == 0) ? 0 : kind + 1;
  endfunction

  // Mask of word bits that carry a flag.
  function automatic logic [WORD_BITS-1:0] used_mask();
    logic [WORD_BITS-1:0] m;
    m = '0;
    for (int unsigned l = 0; l < LANES_PER_WD; l++)
      for (int unsigned k = 0; k < FLAG_KINDS; k++)
        m[lane_base(l) + kind_pos(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dsf_stream_flags.sv
module dsf_stream_flags #(
  parameter int unsigned NKIND = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKIND-1:0] evt_i,
  input  logic [NKIND-1:0] clr_i,
  input  logic [NKIND-1:0] ien_i,
  output logic [NKIND-1:0] flags_o,
  output logic             irq_o
);
  logic [NKIND-1:0] flags_q;
  logic [NKIND-1:0] flags_d;
  logic [NKIND-1:0] armed;

  // Set has priority over clear on the same flag.
  always_comb flags_d = (flags_q & ~clr_i) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign armed   = flags_q & ien_i;
  assign irq_o   = |armed;
  assign flags_o = flags_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && clr_i == '0) |=> $stable(flags_o));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((flags_o & $past(clr_i & ~evt_i)) == '0));

  assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & evt_i) != '0) |=> ((flags_o & $past(clr_i & evt_i)) == $past(clr_i & evt_i)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i == '0 || flags_o == '0) |-> !irq_o);
endmodule

// File: rtl/dsf_word_map.sv
module dsf_word_map
  import dsf_pkg::*;
#(
  parameter int unsigned NKIND  = FLAG_KINDS,
  parameter int unsigned LANES  = LANES_PER_WD,
  parameter int unsigned DATA_W = WORD_BITS
) (
  input  logic [LANES*NKIND-1:0] flags_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      word_o,
  output logic [LANES*NKIND-1:0] wbits_o
);
  // Packs lane flags into a word and picks clear bits out of a written word.
  always_comb begin
    word_o  = '0;
    wbits_o = '0;
    for (int unsigned l = 0; l < LANES; l++) begin
      for (int unsigned k = 0; k < NKIND; k++) begin
        word_o[lane_base(l) + kind_pos(k)] = flags_i[l*NKIND + k];
        wbits_o[l*NKIND + k]               = wdata_i[lane_base(l) + kind_pos(k)];
      end
    end
  end
endmodule

// File: rtl/dma_status_bank.sv
module dma_status_bank
  import dsf_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  parameter int unsigned NKIND       = FLAG_KINDS,
  parameter int unsigned LANES       = LANES_PER_WD,
  parameter int unsigned DATA_W      = WORD_BITS,
  localparam int unsigned NUM_WORDS  = NUM_STREAMS / LANES,
  localparam int unsigned ADDR_W     = $clog2(2 * NUM_WORDS),
  localparam int unsigned NBITS      = NUM_STREAMS * NKIND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBITS-1:0]  evt_i,
  input  logic [NBITS-1:0]  irq_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_STREAMS-1:0] irq_o
);
  localparam int unsigned WBITS = LANES * NKIND;

  logic [NBITS-1:0]     flags_all;
  logic [NBITS-1:0]     clr_all;
  logic [DATA_W-1:0]    status_word [NUM_WORDS];
  logic [NUM_WORDS-1:0] clr_sel;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WBITS-1:0] wbits;

    assign clr_sel[w] = reg_wr_i && (reg_addr_i == ADDR_W'(NUM_WORDS + w));

    dsf_word_map #(.NKIND(NKIND), .LANES(LANES), .DATA_W(DATA_W)) map_i (
      .flags_i (flags_all[w*WBITS +: WBITS]),
      .wdata_i (reg_wdata_i),
      .word_o  (status_word[w]),
      .wbits_o (wbits)
    );

    assign clr_all[w*WBITS +: WBITS] = wbits & {WBITS{clr_sel[w]}};
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    dsf_stream_flags #(.NKIND(NKIND)) flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i[s*NKIND +: NKIND]),
      .clr_i   (clr_all[s*NKIND +: NKIND]),
      .ien_i   (irq_en_i[s*NKIND +: NKIND]),
      .flags_o (flags_all[s*NKIND +: NKIND]),
      .irq_o   (irq_o[s])
    );
  end

  // Status words read back; clear words read as zero.
  always_comb begin
    reg_rdata_o = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++)
      if (reg_addr_i == ADDR_W'(w)) reg_rdata_o = status_word[w];
  end

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~used_mask()) == '0);

  assert_clr_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i >= ADDR_W'(NUM_WORDS)) |-> (reg_rdata_o == '0));

  assert_no_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i < ADDR_W'(NUM_WORDS)) |-> (clr_all == '0));
endmodule

// File: tb/dma_status_bank_tb_top.sv
`timescale 1ns/1ps
module dma_status_bank_tb_top;
  localparam int NS = 8;
  localparam int NF = 5;
  localparam int NB = NS * NF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] evt = '0;
  logic [NB-1:0] ien = '0;
  logic [1:0]    addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wd = '0;
  logic [31:0]   rd;
  logic [NS-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] mdl = '0;

  always #4 clk = ~clk;

  dma_status_bank dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .irq_en_i(ien),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .irq_o(irq)
  );

  // Bit of stream s, kind f within its word (R3 layout).
  function automatic int bitpos(int s, int f);
    int lane = s % 4;
    return (lane / 2) * 16 + (lane % 2) * 6 + ((f == 0) ? 0 : f + 1);
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a, logic [NB-1:0] m);
    logic [31:0] v = '0;
    if (a[1]) return '0;
    for (int s = a[0] * 4; s < a[0] * 4 + 4; s++)
      for (int f = 0; f < NF; f++)
        v[bitpos(s, f)] = m[s*NF + f];
    return v;
  endfunction

  function automatic logic [31:0] rsvd_mask();
    logic [31:0] v = '1;
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < NF; f++) v[bitpos(s, f)] = 1'b0;
    return v;
  endfunction

  function automatic logic [NS-1:0] exp_irq(logic [NB-1:0] m, logic [NB-1:0] e);
    logic [NS-1:0] v = '0;
    for (int s = 0; s < NS; s++)
      for (int f = 0; f < NF; f++)
        if (m[s*NF + f] && e[s*NF + f]) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [NB-1:0] rnd_bits(int sparse);
    logic [NB-1:0] v;
    v = {$urandom, $urandom};
    for (int i = 0; i < sparse; i++) v &= {$urandom, $urandom};
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check the outputs for the state left by the previous edge, then drive new
  // inputs and fold the coming edge into the model.
  task automatic step(string req, logic [NB-1:0] e, logic w, logic [1:0] a,
                      logic [31:0] d);
    logic [NB-1:0] clr = '0;
    @(negedge clk);
    chk(req, rd, exp_read(addr, mdl));
    chk(req, 32'(irq), 32'(exp_irq(mdl, ien)));
    evt = e; wr = w; addr = a; wd = d;
    @(posedge clk);
    if (w && a[1])
      for (int s = a[0] * 4; s < a[0] * 4 + 4; s++)
        for (int f = 0; f < NF; f++)
          clr[s*NF + f] = d[bitpos(s, f)];
    if (!rst_n) mdl = '0;
    else        mdl = (mdl & ~clr) | e;
  endtask

  task automatic idle(string req, logic [1:0] a);
    step(req, '0, 1'b0, a, '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, with events offered during reset
    ien = '1;
    for (int a = 0; a < 4; a++) step("R1", '1, 1'b0, 2'(a), '0);
    idle("R1", 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 2'd1);

    // R2/R3: each flag alone, read back at its place, then cleared
    ien = '0;
    for (int s = 0; s < NS; s++)
      for (int f = 0; f < NF; f++) begin
        logic [NB-1:0] one = '0;
        one[s*NF + f] = 1'b1;
        step("R2", one, 1'b0, 2'(s / 4), '0);
        idle("R3", 2'(s / 4));
        step("R3", '0, 1'b1, 2'(2 + s / 4), 32'(1) << bitpos(s, f));
      end
    idle("R5", 2'd0);

    // R4: every flag set, unused bits still zero
    step("R2", '1, 1'b0, 2'd0, '0);
    @(negedge clk); chk("R4", rd & rsvd_mask(), '0);
    idle("R4", 2'd1);
    @(negedge clk); chk("R4", rd & rsvd_mask(), '0);

    // R6: writes to status words leave flags alone
    step("R6", '0, 1'b1, 2'd0, '1);
    step("R6", '0, 1'b1, 2'd1, '1);
    idle("R6", 2'd0);
    idle("R6", 2'd1);

    // R9: clear words read zero while flags are set
    idle("R9", 2'd2);
    idle("R9", 2'd3);

    // R5: zero write keeps flags; ones clear only their own word
    step("R5", '0, 1'b1, 2'd2, '0);
    idle("R5", 2'd0);
    step("R5", '0, 1'b1, 2'd2, '1);
    idle("R5", 2'd1);
    idle("R5", 2'd0);
    step("R5", '0, 1'b1, 2'd3, 32'h0000_0021);
    idle("R5", 2'd1);

    // R7: event and clear on the same flag at the same edge
    step("R7", 40'h80_0000_0001, 1'b1, 2'd2, '1);
    step("R7", '0, 1'b0, 2'd0, '0);
    step("R7", 40'h80_0000_0000, 1'b1, 2'd3, '1);
    idle("R7", 2'd1);

    // R8: interrupt under enable patterns
    ien = '0;
    idle("R8", 2'd0);
    ien = '1;
    idle("R8", 2'd1);
    ien = 40'h00_0000_0020;
    idle("R8", 2'd0);

    // Random mix of events, clears, status writes and enables
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      ien = rnd_bits(0);
      step("R2_R5_R8", rnd_bits(3), ($urandom_range(0, 2) == 0), a,
           $urandom & $urandom);
    end
    idle("R7", 2'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule